// File: doc/BRIEF.md
# In-band interrupt request controller

This block is the target-side request logic for an I3C in-band interrupt. Software writes one control word that holds a 2-bit event field, an 8-bit data byte and a 4-bit address-map index. Writing the IBI event code arms a request. The block then waits until the bus has been idle long enough: SDA and SCL must both be high for a programmed number of slow-clock ticks.

Once the bus is available, the block offers the request, together with the data byte and the index, to the bus engine over a valid/accept handshake. After the engine accepts, it tracks the request until the engine reports done or fail. It then clears the event field without software help and emits a one-cycle end pulse with an outcome code. The bit-level driving of SDA and arbitration belong to the bus engine.

While a request is outstanding, software can only cancel it. It does so by writing 0, and only before the engine has accepted the request. Clearing the target enable drops any request at any stage. Software normally programs the idle match value to 47 ticks. That is at least 1 µs of idle bus at the usual slow clock.

Top module: `ibi_req_ctrl`

## Requirements
- R1: After reset, eventField is 0, reqValid is 0, endValid is 0, and the idle count is 0.
- R2: In the control word, bits 1:0 are the event field (0 = none, 1 = IBI), bits 7:4 are the index and bits 15:8 are the data byte. While idle and enabled, a write with event 1 makes eventField read 1 from the next cycle on. The same write presents the data byte on reqData and the index on reqIndex.
- R3: While idle, a write with event value 2 or 3 is ignored. eventField stays 0 and no request is raised.
- R4: The idle count rises by one on each cycle that has slowTick high and both SDA and SCL high. It saturates at its all-ones value. Any cycle with SDA or SCL low restarts it at 0. busAvail is high when SDA and SCL are both high and the count is at least busMatch.
- R5: A pending request raises reqValid one cycle after busAvail is seen high. reqValid then stays high until engAccept, a cancel, or a drop.
- R6: While a request is outstanding, a write with a non-zero event value changes nothing: not eventField, not reqData, not reqIndex.
- R7: Writing event 0 while the request waits for the bus, or while reqValid is high, cancels it. This holds even if engAccept is high in the same cycle. In the next cycle eventField is 0, reqValid is 0, and endValid pulses with endCode 1.
- R8: After engAccept, a write of event 0 is ignored and eventField stays 1.
- R9: In flight, engDone returns eventField to 0 in the next cycle and pulses endValid with endCode 0. engFail does the same with endCode 2.
- R10: While tgtEnable is low, any outstanding request is dropped: eventField goes to 0 and endValid pulses with endCode 3. Writes made while tgtEnable is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| tgtEnable | input | 1 | Target enable; low drops any request |
| slowTick | input | 1 | One-cycle pulse per slow-clock period |
| sdaIn | input | 1 | Synchronized SDA level |
| sclIn | input | 1 | Synchronized SCL level |
| busMatch | input | CNT_W | Idle ticks needed for bus-available |
| ctrlWr | input | 1 | Control word write strobe |
| ctrlWrData | input | 16 | Control word: event, index, data byte |
| eventField | output | 2 | Current event field value |
| reqValid | output | 1 | Request offered to the bus engine |
| reqData | output | 8 | IBI data byte for the engine |
| reqIndex | output | 4 | Address-map index for the engine |
| engAccept | input | 1 | Engine has taken the request onto the bus |
| engDone | input | 1 | Engine finished the request |
| engFail | input | 1 | Engine gave up on the request |
| busAvail | output | 1 | Bus-available condition |
| endValid | output | 1 | One-cycle pulse when a request ends |
| endCode | output | 2 | Outcome: 0 done, 1 cancel, 2 fail, 3 drop |

## Verification
The bench builds the block with CNT_W = 4. With that width the idle counter can reach its saturation value of 15 in a few cycles. This lets a match of 15 and counts well past it be checked alongside small matches and a match of 0. Data and index widths stay at 8 and 4, so every control-word field is exercised at its real position.

// File: rtl/ibi_pkg.sv
package ibi_pkg;
  localparam int IDX_W = 4;
  localparam int EVT_W = 2;

  localparam logic [EVT_W-1:0] EVT_NONE = 2'd0;
  localparam logic [EVT_W-1:0] EVT_IBI  = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REQ,
    ST_FLIGHT
  } ibiState_e;

  typedef enum logic [1:0] {
    END_DONE   = 2'd0,
    END_CANCEL = 2'd1,
    END_FAIL   = 2'd2,
    END_DROP   = 2'd3
  } ibiEnd_e;

  typedef struct packed {
    logic loadPayload;
    logic clearPayload;
  } ibiStrobe_t;
endpackage

// File: rtl/ibi_ctrl.sv
module ibi_ctrl
  import ibi_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tgtEnable,
  input  logic             ctrlWr,
  input  logic [EVT_W-1:0] wrEvent,
  input  logic             busAvail,
  input  logic             engAccept,
  input  logic             engDone,
  input  logic             engFail,
  output ibiStrobe_t       strobe,
  output logic [EVT_W-1:0] eventField,
  output logic             reqValid,
  output logic             endValid,
  output logic [1:0]       endCode
);
  ibiState_e st, stNext;
  logic      endNext;
  ibiEnd_e   codeNext;
  logic      cancelWr;

  assign cancelWr = ctrlWr && (wrEvent == EVT_NONE);

  always_comb begin
    stNext   = st;
    endNext  = 1'b0;
    codeNext = END_DONE;
    strobe   = '0;
    if (!tgtEnable) begin
      if (st != ST_IDLE) begin
        stNext              = ST_IDLE;
        endNext             = 1'b1;
        codeNext            = END_DROP;
        strobe.clearPayload = 1'b1;
      end
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (ctrlWr && wrEvent == EVT_IBI) begin
            stNext             = ST_WAIT;
            strobe.loadPayload = 1'b1;
          end
        end
        ST_WAIT: begin
          if (cancelWr) begin
            stNext              = ST_IDLE;
            endNext             = 1'b1;
            codeNext            = END_CANCEL;
            strobe.clearPayload = 1'b1;
          end else if (busAvail) begin
            stNext = ST_REQ;
          end
        end
        ST_REQ: begin
          if (cancelWr) begin
            stNext              = ST_IDLE;
            endNext             = 1'b1;
            codeNext            = END_CANCEL;
            strobe.clearPayload = 1'b1;
          end else if (engAccept) begin
            stNext = ST_FLIGHT;
          end
        end
        ST_FLIGHT: begin
          if (engDone) begin
            stNext              = ST_IDLE;
            endNext             = 1'b1;
            codeNext            = END_DONE;
            strobe.clearPayload = 1'b1;
          end else if (engFail) begin
            stNext              = ST_IDLE;
            endNext             = 1'b1;
            codeNext            = END_FAIL;
            strobe.clearPayload = 1'b1;
          end
        end
        default: stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      endValid <= 1'b0;
      endCode  <= END_DONE;
    end else begin
      st       <= stNext;
      endValid <= endNext;
      endCode  <= codeNext;
    end
  end

  assign eventField = (st == ST_IDLE) ? EVT_NONE : EVT_IBI;
  assign reqValid   = (st == ST_REQ);

  // R5: a request is only offered after the bus was seen available
  assert_rise_needs_avail_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> $past(busAvail));

  // R5: the offer is held until the engine accepts it, or a cancel or drop
  assert_offer_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !engAccept && tgtEnable && !cancelWr) |=> reqValid);

  // R8: once accepted, the field holds until the engine finishes
  assert_flight_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_FLIGHT && tgtEnable && !engDone && !engFail) |=> (eventField == EVT_IBI));

  // R9: a completed request clears the field and reports done
  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_FLIGHT && tgtEnable && engDone) |=> (eventField == EVT_NONE && endValid && endCode == END_DONE));

  // R9: the end pulse lasts a single cycle
  assert_end_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    endValid |=> !endValid);

  // R10: a disabled target holds no request
  assert_disable_drops_R10: assert property (@(posedge clk) disable iff (!rstN)
    !tgtEnable |=> (eventField == EVT_NONE && !reqValid));
endmodule

// File: rtl/ibi_datapath.sv
module ibi_datapath
  import ibi_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ibiStrobe_t        strobe,
  input  logic              slowTick,
  input  logic              sdaIn,
  input  logic              sclIn,
  input  logic [CNT_W-1:0]  busMatch,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  wrIndex,
  output logic              busAvail,
  output logic [DATA_W-1:0] reqData,
  output logic [IDX_W-1:0]  reqIndex
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] idleCnt;
  logic             linesHigh;

  assign linesHigh = sdaIn && sclIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (!linesHigh) begin
      idleCnt <= '0;
    end else if (slowTick && idleCnt != CNT_MAX) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  assign busAvail = linesHigh && (idleCnt >= busMatch);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqData  <= '0;
      reqIndex <= '0;
    end else if (strobe.loadPayload) begin
      reqData  <= wrData;
      reqIndex <= wrIndex;
    end else if (strobe.clearPayload) begin
      reqData  <= '0;
      reqIndex <= '0;
    end
  end

  // R4: a low line restarts the idle count
  assert_idle_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    !linesHigh |=> (idleCnt == '0));

  // R4: the count saturates rather than wrapping
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (idleCnt == CNT_MAX) |=> (idleCnt == CNT_MAX || idleCnt == '0));

  // R6: the payload moves only on a load or a clear strobe
  assert_payload_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadPayload && !strobe.clearPayload) |=> ($stable(reqData) && $stable(reqIndex)));
endmodule

// File: rtl/ibi_req_ctrl.sv
module ibi_req_ctrl
  import ibi_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  localparam int CTRL_W = 8 + DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tgtEnable,
  input  logic              slowTick,
  input  logic              sdaIn,
  input  logic              sclIn,
  input  logic [CNT_W-1:0]  busMatch,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] ctrlWrData,
  output logic [1:0]        eventField,
  output logic              reqValid,
  output logic [DATA_W-1:0] reqData,
  output logic [IDX_W-1:0]  reqIndex,
  input  logic              engAccept,
  input  logic              engDone,
  input  logic              engFail,
  output logic              busAvail,
  output logic              endValid,
  output logic [1:0]        endCode
);
  ibiStrobe_t strobe;
  logic       unusedCtrlBits;

  assign unusedCtrlBits = ^ctrlWrData[3:2];

  ibi_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tgtEnable  (tgtEnable),
    .ctrlWr     (ctrlWr),
    .wrEvent    (ctrlWrData[EVT_W-1:0]),
    .busAvail   (busAvail),
    .engAccept  (engAccept),
    .engDone    (engDone),
    .engFail    (engFail),
    .strobe     (strobe),
    .eventField (eventField),
    .reqValid   (reqValid),
    .endValid   (endValid),
    .endCode    (endCode)
  );

  ibi_datapath #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .slowTick (slowTick),
    .sdaIn    (sdaIn),
    .sclIn    (sclIn),
    .busMatch (busMatch),
    .wrData   (ctrlWrData[8 +: DATA_W]),
    .wrIndex  (ctrlWrData[4 +: IDX_W]),
    .busAvail (busAvail),
    .reqData  (reqData),
    .reqIndex (reqIndex)
  );
endmodule

// File: tb/test_ibi_req_ctrl.sv
module test_ibi_req_ctrl;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tgtEnable = 1'b1;
  logic slowTick = 1'b1;
  logic sdaIn = 1'b1;
  logic sclIn = 1'b1;
  logic [CNT_W-1:0] busMatch = '0;
  logic ctrlWr = 1'b0;
  logic [15:0] ctrlWrData = '0;
  logic engAccept = 1'b0;
  logic engDone = 1'b0;
  logic engFail = 1'b0;
  logic [1:0] eventField;
  logic reqValid;
  logic [7:0] reqData;
  logic [3:0] reqIndex;
  logic busAvail;
  logic endValid;
  logic [1:0] endCode;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  ibi_req_ctrl #(.CNT_W(CNT_W), .DATA_W(8)) i_ibi_req_ctrl (
    .clk(clk), .rstN(rstN), .tgtEnable(tgtEnable), .slowTick(slowTick),
    .sdaIn(sdaIn), .sclIn(sclIn), .busMatch(busMatch), .ctrlWr(ctrlWr),
    .ctrlWrData(ctrlWrData), .eventField(eventField), .reqValid(reqValid),
    .reqData(reqData), .reqIndex(reqIndex), .engAccept(engAccept),
    .engDone(engDone), .engFail(engFail), .busAvail(busAvail),
    .endValid(endValid), .endCode(endCode)
  );

  // idle-count vectors: match value, high ticks after a low cycle, expected busAvail
  localparam int NV = 8;
  localparam int VM [NV] = '{3, 3, 0, 15, 15, 15, 5, 1};
  localparam int VN [NV] = '{2, 3, 0, 14, 15, 20, 7, 0};
  localparam int VE [NV] = '{0, 1, 1, 0, 1, 1, 1, 0};

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] data, input logic [3:0] idx, input logic [1:0] evt);
    ctrlWr = 1'b1;
    ctrlWrData = {data, idx, 2'b00, evt};
    nxt();
    ctrlWr = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    sdaIn = 1'b0;
    nxt(); nxt();
    rstN = 1'b1;
    #1;
    check("R1 eventField", eventField, 0);
    check("R1 reqValid", reqValid, 0);
    check("R1 endValid", endValid, 0);
    busMatch = 4'd1;
    sdaIn = 1'b1;
    #1;
    check("R1 count zero", busAvail, 0);

    // R4 table walk
    for (int i = 0; i < NV; i++) begin
      nxt();
      busMatch = VM[i][CNT_W-1:0];
      sdaIn = 1'b0;
      slowTick = 1'b1;
      nxt();
      sdaIn = 1'b1;
      for (int k = 0; k < VN[i]; k++) nxt();
      #1;
      check($sformatf("R4 vector %0d", i), busAvail, VE[i]);
    end

    // R4: no growth without tick, low SCL restarts
    busMatch = 4'd2;
    sclIn = 1'b0;
    nxt();
    sclIn = 1'b1;
    slowTick = 1'b0;
    repeat (5) nxt();
    #1;
    check("R4 no tick no count", busAvail, 0);
    slowTick = 1'b1;
    nxt(); nxt();
    #1;
    check("R4 ticks count", busAvail, 1);

    // R3: event 2 and 3 ignored
    wr(8'h11, 4'h2, 2'd2);
    check("R3 event 2", eventField, 0);
    wr(8'h11, 4'h2, 2'd3);
    nxt();
    #1;
    check("R3 event 3", eventField, 0);
    check("R3 no request", reqValid, 0);

    // R2/R5/R9: full request, done
    busMatch = 4'd2;
    wr(8'hA5, 4'h3, 2'd1);
    check("R2 field", eventField, 1);
    check("R2 data", reqData, 8'hA5);
    check("R2 index", reqIndex, 3);
    check("R5 waiting", reqValid, 0);
    nxt();
    #1;
    check("R5 offered", reqValid, 1);
    nxt(); nxt();
    #1;
    check("R5 held", reqValid, 1);
    engAccept = 1'b1;
    nxt();
    engAccept = 1'b0;
    #1;
    check("R5 accepted", reqValid, 0);
    wr(8'h00, 4'h0, 2'd0);
    check("R8 zero in flight ignored", eventField, 1);
    check("R8 no end", endValid, 0);
    engDone = 1'b1;
    nxt();
    engDone = 1'b0;
    #1;
    check("R9 done field", eventField, 0);
    check("R9 done pulse", endValid, 1);
    check("R9 done code", endCode, 0);
    nxt();
    #1;
    check("R9 pulse single", endValid, 0);

    // R6/R7: cancel while waiting for bus
    sdaIn = 1'b0;
    wr(8'h3C, 4'h9, 2'd1);
    wr(8'hFF, 4'hF, 2'd1);
    check("R6 data kept", reqData, 8'h3C);
    check("R6 index kept", reqIndex, 9);
    wr(8'hEE, 4'h1, 2'd3);
    check("R6 field kept", eventField, 1);
    check("R6 data kept after 3", reqData, 8'h3C);
    wr(8'h00, 4'h0, 2'd0);
    check("R7 cancel wait field", eventField, 0);
    check("R7 cancel pulse", endValid, 1);
    check("R7 cancel code", endCode, 1);

    // R7: cancel during offer, with accept in the same cycle
    sdaIn = 1'b1;
    busMatch = 4'd0;
    wr(8'h42, 4'h4, 2'd1);
    nxt();
    #1;
    check("R7 offer up", reqValid, 1);
    engAccept = 1'b1;
    wr(8'h00, 4'h0, 2'd0);
    engAccept = 1'b0;
    check("R7 cancel offer field", eventField, 0);
    check("R7 cancel offer valid", reqValid, 0);
    check("R7 cancel offer code", endCode, 1);

    // R9: fail outcome
    wr(8'h77, 4'h7, 2'd1);
    nxt();
    engAccept = 1'b1;
    nxt();
    engAccept = 1'b0;
    engFail = 1'b1;
    nxt();
    engFail = 1'b0;
    #1;
    check("R9 fail field", eventField, 0);
    check("R9 fail pulse", endValid, 1);
    check("R9 fail code", endCode, 2);

    // R10: drop on disable, writes ignored while disabled
    sdaIn = 1'b0;
    wr(8'h55, 4'h5, 2'd1);
    tgtEnable = 1'b0;
    nxt();
    #1;
    check("R10 drop field", eventField, 0);
    check("R10 drop pulse", endValid, 1);
    check("R10 drop code", endCode, 3);
    wr(8'h66, 4'h6, 2'd1);
    nxt();
    #1;
    check("R10 write ignored", eventField, 0);
    tgtEnable = 1'b1;
    wr(8'h66, 4'h6, 2'd1);
    check("R10 reenabled", eventField, 1);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule